// File: doc/BRIEF.md
# Priority Rule-Table State Machine Engine

This block is a Mealy state machine whose behaviour lives in a writable table instead of fixed logic. Each state owns a short ordered list of rules. A rule holds a valid flag, a guard, a destination state and an output vector. The guard is stored as a truth-table mask over the input vector, so any Boolean function of the inputs can be expressed. That includes functions built from AND, OR, XOR and NOT, and the all-ones mask that matches every input.

On every cycle the engine looks at the rules of the current state in ascending index order. The first valid rule whose guard accepts the present inputs decides two things: the state for the next cycle, and the output vector registered at the same edge. If no rule accepts, the state holds and the registered outputs go to zero.

Software loads the table through a simple write port while the engine is stopped (run enable low). Synchronous reset returns the machine to state 0, clears the outputs and invalidates every rule.

Top module: `rule_fsm_engine`

## Requirements
- R1: While `rst` is high at a rising edge, the following hold after that edge: `state_q` is 0, `out_q` is 0 and every rule is invalid.
- R2: A write with `cfg_we` high is stored only when `run_en` and `rst` are both low at the edge. A write made while `run_en` is high leaves the table unchanged.
- R3: While `run_en` is low, `state_q` holds its value and `out_q` is 0 after the edge.
- R4: With `run_en` high, the rules of the current state are checked in ascending index from 0. Only the lowest-indexed matching rule sets `state_q` and `out_q` at the next edge.
- R5: With `run_en` high and no matching rule, `state_q` holds and `out_q` becomes 0.
- R6: A rule's guard is a 2^N_INPUTS-bit mask. The rule accepts the input vector `in_x` when mask bit number `in_x` is 1. The mask 16'hFFFF (default) accepts every input.
- R7: A rule whose valid bit is 0 never matches, whatever its mask.
- R8: `out_q` is the output vector of the rule taken on the previous edge. It is registered at the same edge as `state_q`, so an output rises in the cycle after the input that triggers it was sampled.
- R9: An edge detector loaded with states Initial=0, Low=1 and High=2 (input bit 0 is x) outputs 1 only on the move from Low to High. It outputs 0 when x is already 1 in the first cycle.
- R10: A resettable sticky bit (bit 0 = x, bit 1 = r) is loaded with two rules in its set state: first "r: go to 0, output 0", then default "stay, output 1". With r=1 the first rule wins even though the default also matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Engine steps when high; table writable when low |
| cfg_we | input | 1 | Table write strobe |
| cfg_state | input | 3 | State whose rule is written |
| cfg_rule | input | 2 | Rule index within that state (0 = highest priority) |
| cfg_valid | input | 1 | Valid bit of the written rule |
| cfg_mask | input | 16 | Guard truth-table mask of the written rule |
| cfg_next | input | 3 | Destination state of the written rule |
| cfg_out | input | 4 | Output vector of the written rule |
| in_x | input | 4 | Machine inputs |
| state_q | output | 3 | Current state |
| out_q | output | 4 | Registered outputs |

## Verification
The bench builds the engine with its default parameters: 8 states, 4 rules per state, 4 inputs and 4 outputs. The table therefore has only 32 entries and each guard addresses 16 input codes, which is small enough to fill every entry with arithmetically derived masks, destinations and valid bits. Long input sequences then reach most state and input-code pairs, including no-match cycles, invalid leading rules and default rules. The two hand-loaded machines, the edge detector and the sticky bit, cover the priority and first-cycle corner cases directly.

// File: rtl/rule_fsm_engine.sv
module rule_fsm_engine #(
  parameter int N_STATES  = 8,
  parameter int N_INPUTS  = 4,
  parameter int N_RULES   = 4,
  parameter int N_OUTPUTS = 4,
  localparam int SW = (N_STATES > 1) ? $clog2(N_STATES) : 1,
  localparam int RW = (N_RULES > 1) ? $clog2(N_RULES) : 1,
  localparam int MW = 1 << N_INPUTS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run_en,
  input  logic                 cfg_we,
  input  logic [SW-1:0]        cfg_state,
  input  logic [RW-1:0]        cfg_rule,
  input  logic                 cfg_valid,
  input  logic [MW-1:0]        cfg_mask,
  input  logic [SW-1:0]        cfg_next,
  input  logic [N_OUTPUTS-1:0] cfg_out,
  input  logic [N_INPUTS-1:0]  in_x,
  output logic [SW-1:0]        state_q,
  output logic [N_OUTPUTS-1:0] out_q
);
  localparam int NE = N_STATES * N_RULES;

  logic                 tv [NE];
  logic [MW-1:0]        tm [NE];
  logic [SW-1:0]        tn [NE];
  logic [N_OUTPUTS-1:0] to [NE];

  logic                 cfg_wr;
  logic                 hit;
  logic [SW-1:0]        nxt;
  logic [N_OUTPUTS-1:0] nout;

  assign cfg_wr = cfg_we && !run_en && !rst && (int'(cfg_state) < N_STATES)
                  && (int'(cfg_rule) < N_RULES);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < NE; e++) tv[e] <= 1'b0;
    end else if (cfg_wr) begin
      tv[int'(cfg_state) * N_RULES + int'(cfg_rule)] <= cfg_valid;
      tm[int'(cfg_state) * N_RULES + int'(cfg_rule)] <= cfg_mask;
      tn[int'(cfg_state) * N_RULES + int'(cfg_rule)] <= cfg_next;
      to[int'(cfg_state) * N_RULES + int'(cfg_rule)] <= cfg_out;
    end
  end

  // lowest index scanned last so it wins
  always_comb begin
    hit  = 1'b0;
    nxt  = state_q;
    nout = '0;
    for (int r = N_RULES - 1; r >= 0; r--) begin
      if (tv[int'(state_q) * N_RULES + r] && tm[int'(state_q) * N_RULES + r][in_x]) begin
        hit  = 1'b1;
        nxt  = tn[int'(state_q) * N_RULES + r];
        nout = to[int'(state_q) * N_RULES + r];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      out_q   <= '0;
    end else if (run_en) begin
      state_q <= nxt;
      out_q   <= nout;
    end else begin
      out_q   <= '0;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (state_q == '0) && (out_q == '0)); // R1
  AST_IDLE_OUT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (out_q == '0)); // R3
  AST_IDLE_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> $stable(state_q)); // R3
  AST_NOMATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run_en && !hit) |=> $stable(state_q) && (out_q == '0)); // R5
endmodule

// File: tb/rule_fsm_engine_tb_top.sv
module rule_fsm_engine_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, run_en = 1'b0, cfg_we = 1'b0, cfg_valid = 1'b0;
  logic [2:0] cfg_state = '0, cfg_next = '0;
  logic [1:0] cfg_rule = '0;
  logic [15:0] cfg_mask = '0;
  logic [3:0] cfg_out = '0, in_x = '0;
  logic [2:0] state_q;
  logic [3:0] out_q;

  rule_fsm_engine dut_i (
    .clk(clk), .rst(rst), .run_en(run_en), .cfg_we(cfg_we),
    .cfg_state(cfg_state), .cfg_rule(cfg_rule), .cfg_valid(cfg_valid),
    .cfg_mask(cfg_mask), .cfg_next(cfg_next), .cfg_out(cfg_out),
    .in_x(in_x), .state_q(state_q), .out_q(out_q));

  int checks = 0, fails = 0;
  bit done = 0;
  bit        mv [32];
  logic [15:0] mm [32];
  logic [2:0]  mn [32];
  logic [3:0]  mo [32];
  logic [2:0]  es;
  logic [3:0]  eo;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; run_en = 0; cfg_we = 0;
    @(posedge clk); #1;
    for (int e = 0; e < 32; e++) mv[e] = 0;
    es = 0; eo = 0;
    chk("R1 state", state_q, 0);
    chk("R1 out", out_q, 0);
    @(negedge clk); rst = 0;
  endtask

  task automatic wr(input int s, input int r, input bit v, input logic [15:0] m,
                    input int n, input int o, input bit run);
    @(negedge clk);
    cfg_we = 1; cfg_state = 3'(s); cfg_rule = 2'(r); cfg_valid = v;
    cfg_mask = m; cfg_next = 3'(n); cfg_out = 4'(o); run_en = run;
    @(posedge clk);
    if (run) begin
      int hit = 0;
      logic [2:0] ns = es;
      logic [3:0] no = 0;
      for (int k = 0; k < 4; k++)
        if (!hit && mv[es*4+k] && mm[es*4+k][in_x]) begin
          hit = 1; ns = mn[es*4+k]; no = mo[es*4+k];
        end
      es = ns; eo = no;
    end else begin
      mv[s*4+r] = v; mm[s*4+r] = m; mn[s*4+r] = 3'(n); mo[s*4+r] = 4'(o); eo = 0;
    end
    #1;
    @(negedge clk); cfg_we = 0; run_en = 0;
  endtask

  task automatic cyc(input logic [3:0] x, input bit run, input string tag);
    @(negedge clk); in_x = x; run_en = run;
    @(posedge clk);
    if (run) begin
      int hit = 0;
      logic [2:0] ns = es;
      logic [3:0] no = 0;
      for (int k = 0; k < 4; k++)
        if (!hit && mv[es*4+k] && mm[es*4+k][x]) begin
          hit = 1; ns = mn[es*4+k]; no = mo[es*4+k];
        end
      es = ns; eo = no;
    end else eo = 0;
    #1;
    chk({tag, " state"}, state_q, es);
    chk({tag, " out"}, out_q, eo);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    do_reset();
    cyc(4'd7, 1, "R1 no rules after reset");

    // Edge detector: bit0 = x; Initial 0, Low 1, High 2
    do_reset();
    wr(0, 0, 1, 16'h5555, 1, 0, 0);
    wr(0, 1, 1, 16'hAAAA, 2, 0, 0);
    wr(1, 0, 1, 16'hAAAA, 2, 1, 0);
    wr(2, 0, 1, 16'h5555, 1, 0, 0);
    cyc(4'd1, 1, "R9 first cycle high");
    chk("R9 no pulse at start", out_q, 0);
    cyc(4'd1, 1, "R5 no match in High");
    cyc(4'd0, 1, "R9 to Low");
    cyc(4'd0, 1, "R5 no match in Low");
    cyc(4'd1, 1, "R9 rising");
    chk("R9 pulse", out_q, 1);
    cyc(4'd1, 1, "R9 held high");
    cyc(4'd0, 0, "R3 idle");
    cyc(4'd0, 0, "R3 idle hold");

    // Sticky bit: bit0 = x, bit1 = r; Start 0, Set 1
    do_reset();
    wr(0, 0, 1, 16'h2222, 1, 1, 0);
    wr(1, 0, 1, 16'hCCCC, 0, 0, 0);
    wr(1, 1, 1, 16'hFFFF, 1, 1, 0);
    cyc(4'd0, 1, "R10 idle low");
    cyc(4'd3, 1, "R10 r blocks set");
    cyc(4'd1, 1, "R10 set");
    cyc(4'd0, 1, "R6 default keeps");
    cyc(4'd1, 1, "R6 default keeps");
    chk("R10 sticky out", out_q, 1);
    cyc(4'd3, 1, "R10 r wins over default");
    chk("R10 cleared", state_q, 0);
    // R2: write during run is ignored
    wr(0, 0, 1, 16'hFFFF, 5, 15, 1);
    cyc(4'd0, 1, "R2 ignored write");
    cyc(4'd4, 1, "R2 ignored write");
    // R7: invalid default at index 0 ahead of real rule
    wr(0, 0, 0, 16'hFFFF, 6, 9, 0);
    wr(0, 1, 1, 16'h0002, 1, 1, 0);
    cyc(4'd0, 1, "R7 invalid skipped");
    cyc(4'd1, 1, "R7 valid lower rule");

    // Arithmetic sweeps over the whole table
    for (int p = 0; p < 3; p++) begin
      do_reset();
      for (int e = 0; e < 32; e++) begin
        logic [15:0] m;
        m = 16'((e * 40503 + p * 4099 + 77) ^ (e << (p + 3)));
        if ((e % 4) == 3 && ((e / 4 + p) % 3) == 0) m = 16'hFFFF;
        wr(e / 4, e % 4, ((e + p) % 4) != 3, m, (e * 5 + p + 1) % 8,
           (e * 3 + p * 7) % 16, 0);
      end
      for (int k = 0; k < 300; k++)
        cyc(4'((k * 5 + p * 3 + (k >> 3)) % 16), (k % 17) != 16,
            "R4 R5 R6 R8 sweep");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule